// File: doc/BRIEF.md
# External Master Access Decoder

This block observes a shared memory bus during cycles in which a different device owns the bus. When that device raises the start strobe, the block samples the address, the direction and the transfer size, and sorts the access into exactly one class. The classes are a chip-select window, a DRAM bank or the default memory space. It then raises the memory-control strobes that belong to that class and, where the matched space is configured to do so, answers with a one-cycle acknowledge after a programmable wait.

Each chip-select window and each DRAM bank has a base, an address mask and separate read and write enables. Chip-select windows and the default space also carry an auto-acknowledge flag and a 4-bit wait count. DRAM banks always acknowledge, after their own wait count, once their direction is enabled. When no acknowledge will come from this block, the access stays open until the bus acknowledge line is seen from elsewhere. All outputs are active high, and the block never drives the address.

Top module: `xm_access_decoder`

## Requirements
- R1: On a rising edge where `startStrobe` is high and the block is idle, `addrIn`, `readNotWrite` (1 = read) and `sizeIn` are captured, and that access alone decides the strobes that follow.
- R2: While `upperPinsAlt` is high, bits 27:24 of the captured address are taken as zero before decoding.
- R3: The strobes for an access become visible after the first rising edge that follows the capture edge.
- R4: Address classes are matched as follows. A window matches when `((addr ^ base) & ~mask) == 0`. Chip-select windows take priority in ascending index order, then DRAM banks in ascending order, then default memory. At most one `csOut` bit is high, and `csOut` and `dramSel` are never high together.
- R5: A matched chip-select window raises its `csOut` bit only if it is enabled for the transfer direction. `weOut` is raised only on writes to such a window. Bit i of `weOut` is byte offset i, and the lanes follow `sizeIn`: 00 = four bytes (4'hF), 01 = one byte (lane addr[1:0]), 10 = two bytes (4'h3 if addr[1]=0, else 4'hC), 11 = line (4'hF).
- R6: If a chip-select window is matched, enabled for the direction and has auto-acknowledge set, `ackOut` is high in the cycle after the (ws+2)-th rising edge following the capture edge. Here ws is that window's wait count, so ws=0 gives the acknowledge one cycle after the strobes start.
- R7: If a DRAM bank is matched and enabled for the direction, its `dramSel` bit is raised and `ackOut` follows with the same timing, using the bank's wait count.
- R8: If nothing matches, no `csOut`, `weOut` or `dramSel` bit is raised. `ackOut` follows with the default wait count only when `dfltAutoAck` is set.
- R9: `ackOut` lasts exactly one cycle. All strobes are low on the edge after it, and the block is idle again.
- R10: An access that will not be acknowledged by this block holds its strobes until `busAckIn` is sampled high. They drop on that edge, and no `ackOut` is produced.
- R11: A start strobe that arrives while an access is open is ignored and produces no strobes.
- R12: Reset (`rstN` low) drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| startStrobe | input | 1 | Transfer start from the bus owner |
| addrIn | input | 28 | Transfer address |
| readNotWrite | input | 1 | 1 = read, 0 = write |
| sizeIn | input | 2 | Transfer size code |
| upperPinsAlt | input | 1 | Upper address pins used for another function |
| busAckIn | input | 1 | Acknowledge seen on the bus from elsewhere |
| csBase | input | CS_COUNT*28 | Chip-select window bases |
| csMask | input | CS_COUNT*28 | Chip-select don't-care bits |
| csRdEn | input | CS_COUNT | Window read enables |
| csWrEn | input | CS_COUNT | Window write enables |
| csAutoAck | input | CS_COUNT | Window auto-acknowledge flags |
| csWait | input | CS_COUNT*4 | Window wait counts |
| dramBase | input | DRAM_COUNT*28 | DRAM bank bases |
| dramMask | input | DRAM_COUNT*28 | DRAM don't-care bits |
| dramRdEn | input | DRAM_COUNT | Bank read enables |
| dramWrEn | input | DRAM_COUNT | Bank write enables |
| dramWait | input | DRAM_COUNT*4 | Bank wait counts |
| dfltAutoAck | input | 1 | Default-space auto-acknowledge |
| dfltWait | input | 4 | Default-space wait count |
| csOut | output | CS_COUNT | Chip selects |
| weOut | output | 4 | Byte-lane write enables |
| dramSel | output | DRAM_COUNT | DRAM access indication per bank |
| ackOut | output | 1 | Transfer acknowledge |

## Verification
The bench runs a full cross of eight addresses, both directions and all four size codes. The addresses are one per chip-select window, one where two windows overlap, one per DRAM bank, one in default space, and one that reaches a window only after the upper bits are cleared. Together they separate priority from plain matching, enabled from disabled directions, auto-acknowledged from externally ended accesses, and every lane pattern. Each access compares the strobes, the cycle in which the acknowledge appears and the cleared state afterwards with values computed from the window arithmetic. Separate cases turn off the default acknowledge and fire a second start strobe in the middle of an open access.

// File: rtl/xm_access_pkg.sv
package xm_access_pkg;

  typedef struct packed {
    logic capture;
    logic strobeOn;
    logic strobeOff;
  } dpCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_COUNT,
    ST_ACK,
    ST_EXT
  } accState_e;

endpackage

// File: rtl/xm_access_dp.sv
module xm_access_dp
  import xm_access_pkg::*;
#(
  parameter int unsigned ADDR_W     = 28,
  parameter int unsigned UPPER_W    = 4,
  parameter int unsigned CS_COUNT   = 4,
  parameter int unsigned DRAM_COUNT = 2,
  parameter int unsigned WS_W       = 4,
  parameter int unsigned LANES      = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpCtrl_t                      ctrl,
  input  logic [ADDR_W-1:0]            addrIn,
  input  logic                         readNotWrite,
  input  logic [1:0]                   sizeIn,
  input  logic                         upperPinsAlt,
  input  logic [CS_COUNT*ADDR_W-1:0]   csBase,
  input  logic [CS_COUNT*ADDR_W-1:0]   csMask,
  input  logic [CS_COUNT-1:0]          csRdEn,
  input  logic [CS_COUNT-1:0]          csWrEn,
  input  logic [CS_COUNT-1:0]          csAutoAck,
  input  logic [CS_COUNT*WS_W-1:0]     csWait,
  input  logic [DRAM_COUNT*ADDR_W-1:0] dramBase,
  input  logic [DRAM_COUNT*ADDR_W-1:0] dramMask,
  input  logic [DRAM_COUNT-1:0]        dramRdEn,
  input  logic [DRAM_COUNT-1:0]        dramWrEn,
  input  logic [DRAM_COUNT*WS_W-1:0]   dramWait,
  input  logic                         dfltAutoAck,
  input  logic [WS_W-1:0]              dfltWait,
  output logic [CS_COUNT-1:0]          csOut,
  output logic [LANES-1:0]             weOut,
  output logic [DRAM_COUNT-1:0]        dramSel,
  output logic                         autoAck,
  output logic [WS_W-1:0]              waitCnt
);

  localparam int unsigned LOW_W   = ADDR_W - UPPER_W;
  localparam int unsigned CSIDX_W = (CS_COUNT > 1) ? $clog2(CS_COUNT) : 1;
  localparam int unsigned DRIDX_W = (DRAM_COUNT > 1) ? $clog2(DRAM_COUNT) : 1;
  localparam int unsigned LSEL_W  = $clog2(LANES);

  logic [ADDR_W-1:0] capAddr;
  logic              capRnw;
  logic [1:0]        capSize;

  // capture stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr <= '0;
      capRnw  <= 1'b1;
      capSize <= '0;
    end else if (ctrl.capture) begin
      capAddr <= upperPinsAlt ? {{UPPER_W{1'b0}}, addrIn[LOW_W-1:0]} : addrIn;
      capRnw  <= readNotWrite;
      capSize <= sizeIn;
    end
  end

  // window comparators
  logic [CS_COUNT-1:0]   csHit;
  logic [DRAM_COUNT-1:0] dramHit;

  for (genvar gi = 0; gi < CS_COUNT; gi++) begin : g_csCmp
    assign csHit[gi] = ((capAddr ^ csBase[gi*ADDR_W +: ADDR_W]) &
                        ~csMask[gi*ADDR_W +: ADDR_W]) == '0;
  end

  for (genvar gj = 0; gj < DRAM_COUNT; gj++) begin : g_drCmp
    assign dramHit[gj] = ((capAddr ^ dramBase[gj*ADDR_W +: ADDR_W]) &
                          ~dramMask[gj*ADDR_W +: ADDR_W]) == '0;
  end

  // priority pick
  logic               csFound, dramFound;
  logic [CSIDX_W-1:0] csIdx;
  logic [DRIDX_W-1:0] dramIdx;

  always_comb begin
    csFound = 1'b0;
    csIdx   = '0;
    for (int i = 0; i < CS_COUNT; i++) begin
      if (csHit[i] && !csFound) begin
        csFound = 1'b1;
        csIdx   = CSIDX_W'(i);
      end
    end
    dramFound = 1'b0;
    dramIdx   = '0;
    for (int j = 0; j < DRAM_COUNT; j++) begin
      if (dramHit[j] && !dramFound) begin
        dramFound = 1'b1;
        dramIdx   = DRIDX_W'(j);
      end
    end
  end

  // lane pattern from size and low address bits
  logic [LANES-1:0] laneMask;
  always_comb begin
    unique case (capSize)
      2'b01:   laneMask = LANES'(1) << capAddr[LSEL_W-1:0];
      2'b10:   laneMask = capAddr[1] ? LANES'(4'hC) : LANES'(4'h3);
      default: laneMask = '1;
    endcase
  end

  // class outcome
  logic                  csDirOk, dramDirOk;
  logic [CS_COUNT-1:0]   nextCs;
  logic [LANES-1:0]      nextWe;
  logic [DRAM_COUNT-1:0] nextDram;

  always_comb begin
    csDirOk   = capRnw ? csRdEn[csIdx] : csWrEn[csIdx];
    dramDirOk = capRnw ? dramRdEn[dramIdx] : dramWrEn[dramIdx];
    nextCs    = '0;
    nextWe    = '0;
    nextDram  = '0;
    autoAck   = dfltAutoAck;
    waitCnt   = dfltWait;
    if (csFound) begin
      autoAck = csDirOk && csAutoAck[csIdx];
      waitCnt = csWait[csIdx*WS_W +: WS_W];
      if (csDirOk) begin
        nextCs[csIdx] = 1'b1;
        nextWe        = capRnw ? '0 : laneMask;
      end
    end else if (dramFound) begin
      autoAck = dramDirOk;
      waitCnt = dramWait[dramIdx*WS_W +: WS_W];
      if (dramDirOk) nextDram[dramIdx] = 1'b1;
    end
  end

  // strobe registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csOut   <= '0;
      weOut   <= '0;
      dramSel <= '0;
    end else if (ctrl.strobeOn) begin
      csOut   <= nextCs;
      weOut   <= nextWe;
      dramSel <= nextDram;
    end else if (ctrl.strobeOff) begin
      csOut   <= '0;
      weOut   <= '0;
      dramSel <= '0;
    end
  end

endmodule

// File: rtl/xm_access_ctrl.sv
module xm_access_ctrl
  import xm_access_pkg::*;
#(
  parameter int unsigned WS_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startStrobe,
  input  logic            busAckIn,
  input  logic            autoAck,
  input  logic [WS_W-1:0] waitCnt,
  output dpCtrl_t         ctrl,
  output logic            ackOut
);

  accState_e       state;
  logic [WS_W-1:0] remain;

  always_comb begin
    ctrl.capture   = (state == ST_IDLE) && startStrobe;
    ctrl.strobeOn  = (state == ST_DECODE);
    ctrl.strobeOff = (state == ST_ACK) ||
                     (((state == ST_COUNT) || (state == ST_EXT)) && busAckIn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      remain <= '0;
      ackOut <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startStrobe) state <= ST_DECODE;
        end
        ST_DECODE: begin
          remain <= waitCnt;
          state  <= autoAck ? ST_COUNT : ST_EXT;
        end
        ST_COUNT: begin
          if (busAckIn) begin
            state <= ST_IDLE;
          end else if (remain == '0) begin
            ackOut <= 1'b1;
            state  <= ST_ACK;
          end else begin
            remain <= remain - 1'b1;
          end
        end
        ST_ACK: begin
          ackOut <= 1'b0;
          state  <= ST_IDLE;
        end
        ST_EXT: begin
          if (busAckIn) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xm_access_decoder.sv
module xm_access_decoder
  import xm_access_pkg::*;
#(
  parameter int unsigned ADDR_W     = 28,
  parameter int unsigned UPPER_W    = 4,
  parameter int unsigned CS_COUNT   = 4,
  parameter int unsigned DRAM_COUNT = 2,
  parameter int unsigned WS_W       = 4,
  parameter int unsigned LANES      = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         startStrobe,
  input  logic [ADDR_W-1:0]            addrIn,
  input  logic                         readNotWrite,
  input  logic [1:0]                   sizeIn,
  input  logic                         upperPinsAlt,
  input  logic                         busAckIn,
  input  logic [CS_COUNT*ADDR_W-1:0]   csBase,
  input  logic [CS_COUNT*ADDR_W-1:0]   csMask,
  input  logic [CS_COUNT-1:0]          csRdEn,
  input  logic [CS_COUNT-1:0]          csWrEn,
  input  logic [CS_COUNT-1:0]          csAutoAck,
  input  logic [CS_COUNT*WS_W-1:0]     csWait,
  input  logic [DRAM_COUNT*ADDR_W-1:0] dramBase,
  input  logic [DRAM_COUNT*ADDR_W-1:0] dramMask,
  input  logic [DRAM_COUNT-1:0]        dramRdEn,
  input  logic [DRAM_COUNT-1:0]        dramWrEn,
  input  logic [DRAM_COUNT*WS_W-1:0]   dramWait,
  input  logic                         dfltAutoAck,
  input  logic [WS_W-1:0]              dfltWait,
  output logic [CS_COUNT-1:0]          csOut,
  output logic [LANES-1:0]             weOut,
  output logic [DRAM_COUNT-1:0]        dramSel,
  output logic                         ackOut
);

  dpCtrl_t         ctrl;
  logic            autoAck;
  logic [WS_W-1:0] waitCnt;

  xm_access_ctrl #(.WS_W(WS_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startStrobe (startStrobe),
    .busAckIn    (busAckIn),
    .autoAck     (autoAck),
    .waitCnt     (waitCnt),
    .ctrl        (ctrl),
    .ackOut      (ackOut)
  );

  xm_access_dp #(
    .ADDR_W     (ADDR_W),
    .UPPER_W    (UPPER_W),
    .CS_COUNT   (CS_COUNT),
    .DRAM_COUNT (DRAM_COUNT),
    .WS_W       (WS_W),
    .LANES      (LANES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .addrIn       (addrIn),
    .readNotWrite (readNotWrite),
    .sizeIn       (sizeIn),
    .upperPinsAlt (upperPinsAlt),
    .csBase       (csBase),
    .csMask       (csMask),
    .csRdEn       (csRdEn),
    .csWrEn       (csWrEn),
    .csAutoAck    (csAutoAck),
    .csWait       (csWait),
    .dramBase     (dramBase),
    .dramMask     (dramMask),
    .dramRdEn     (dramRdEn),
    .dramWrEn     (dramWrEn),
    .dramWait     (dramWait),
    .dfltAutoAck  (dfltAutoAck),
    .dfltWait     (dfltWait),
    .csOut        (csOut),
    .weOut        (weOut),
    .dramSel      (dramSel),
    .autoAck      (autoAck),
    .waitCnt      (waitCnt)
  );

endmodule

// File: rtl/xm_access_checker.sv
module xm_access_checker #(
  parameter int unsigned CS_COUNT   = 4,
  parameter int unsigned DRAM_COUNT = 2,
  parameter int unsigned LANES      = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  startStrobe,
  input logic [CS_COUNT-1:0]   csOut,
  input logic [LANES-1:0]      weOut,
  input logic [DRAM_COUNT-1:0] dramSel,
  input logic                  ackOut
);

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csOut)); // R4

  AST_CLASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !((|csOut) && (|dramSel))); // R4

  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    (|weOut) |-> (|csOut)); // R5

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |=> !ackOut); // R9

  AST_CLEAR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |=> (csOut == '0 && weOut == '0 && dramSel == '0)); // R9

  AST_CS_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|csOut) |-> $past(startStrobe, 2)); // R3

endmodule

bind xm_access_decoder xm_access_checker #(
  .CS_COUNT   (CS_COUNT),
  .DRAM_COUNT (DRAM_COUNT),
  .LANES      (LANES)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startStrobe (startStrobe),
  .csOut       (csOut),
  .weOut       (weOut),
  .dramSel     (dramSel),
  .ackOut      (ackOut)
);

// File: tb/xm_access_decoder_bench.sv
module xm_access_decoder_bench;

  localparam int AW = 28;
  localparam int NC = 4;
  localparam int ND = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startStrobe = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic readNotWrite = 1'b1;
  logic [1:0] sizeIn = '0;
  logic upperPinsAlt = 1'b0;
  logic busAckIn = 1'b0;
  logic [NC*AW-1:0] csBase, csMask;
  logic [NC-1:0] csRdEn, csWrEn, csAutoAck;
  logic [NC*4-1:0] csWait;
  logic [ND*AW-1:0] dramBase, dramMask;
  logic [ND-1:0] dramRdEn, dramWrEn;
  logic [ND*4-1:0] dramWait;
  logic dfltAutoAck;
  logic [3:0] dfltWait;
  logic [NC-1:0] csOut;
  logic [3:0] weOut;
  logic [ND-1:0] dramSel;
  logic ackOut;

  int total = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  xm_access_decoder u_xm_access_decoder (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .addrIn(addrIn),
    .readNotWrite(readNotWrite), .sizeIn(sizeIn), .upperPinsAlt(upperPinsAlt),
    .busAckIn(busAckIn), .csBase(csBase), .csMask(csMask), .csRdEn(csRdEn),
    .csWrEn(csWrEn), .csAutoAck(csAutoAck), .csWait(csWait),
    .dramBase(dramBase), .dramMask(dramMask), .dramRdEn(dramRdEn),
    .dramWrEn(dramWrEn), .dramWait(dramWait), .dfltAutoAck(dfltAutoAck),
    .dfltWait(dfltWait), .csOut(csOut), .weOut(weOut), .dramSel(dramSel),
    .ackOut(ackOut)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      total = total + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // expected outcome from the window arithmetic of the requirements
  task automatic model(input logic [AW-1:0] a, input logic rnw, input logic [1:0] sz,
                       input logic alt, output logic [NC-1:0] eCs,
                       output logic [3:0] eWe, output logic [ND-1:0] eDr,
                       output int eAck);
    logic [AW-1:0] ea;
    logic found;
    ea = alt ? {4'h0, a[23:0]} : a;
    eCs = '0; eWe = '0; eDr = '0;
    eAck = dfltAutoAck ? int'(dfltWait) + 1 : 0;
    found = 1'b0;
    for (int i = 0; i < NC; i++) begin
      if (!found && (((ea ^ csBase[i*AW +: AW]) & ~csMask[i*AW +: AW]) == '0)) begin
        found = 1'b1;
        eAck = 0;
        if (rnw ? csRdEn[i] : csWrEn[i]) begin
          eCs[i] = 1'b1;
          if (!rnw) begin
            case (sz)
              2'b01: eWe = 4'b0001 << ea[1:0];
              2'b10: eWe = ea[1] ? 4'hC : 4'h3;
              default: eWe = 4'hF;
            endcase
          end
          if (csAutoAck[i]) eAck = int'(csWait[i*4 +: 4]) + 1;
        end
      end
    end
    for (int j = 0; j < ND; j++) begin
      if (!found && (((ea ^ dramBase[j*AW +: AW]) & ~dramMask[j*AW +: AW]) == '0)) begin
        found = 1'b1;
        eAck = 0;
        if (rnw ? dramRdEn[j] : dramWrEn[j]) begin
          eDr[j] = 1'b1;
          eAck = int'(dramWait[j*4 +: 4]) + 1;
        end
      end
    end
  endtask

  task automatic xfer(input logic [AW-1:0] a, input logic rnw, input logic [1:0] sz,
                      input logic alt);
    logic [NC-1:0] eCs;
    logic [3:0] eWe;
    logic [ND-1:0] eDr;
    int eAck;
    int seen;
    model(a, rnw, sz, alt, eCs, eWe, eDr, eAck);
    @(negedge clk);
    addrIn = a; readNotWrite = rnw; sizeIn = sz; upperPinsAlt = alt;
    startStrobe = 1'b1;
    @(negedge clk);
    startStrobe = 1'b0;
    @(negedge clk);
    // R1 R2 R3 R4 R5 R7 R8: strobes one edge after capture
    chk($sformatf("R3/R4/R5 strobes addr %h rnw %0d sz %0d", a, rnw, sz),
        {24'h0, eDr, eWe, eCs}, {24'h0, dramSel, weOut, csOut});
    seen = 0;
    for (int n = 1; n <= 24; n++) begin
      @(negedge clk);
      if (ackOut) begin
        seen = n;
        break;
      end
    end
    // R6 R7 R8: acknowledge cycle
    chk($sformatf("R6/R7/R8 ack cycle addr %h rnw %0d", a, rnw), seen, eAck);
    if (seen != 0) begin
      @(negedge clk);
      chk("R9 cleared after ack", {27'h0, ackOut, dramSel, csOut, weOut} != 0, 0);
    end else begin
      busAckIn = 1'b1;
      @(negedge clk);
      busAckIn = 1'b0;
      chk("R10 cleared after bus ack", {27'h0, ackOut, dramSel, csOut, weOut} != 0, 0);
    end
  endtask

  logic [AW-1:0] addrs [8];
  logic alts [8];

  initial begin
    // window setup: mask bit 1 means not compared
    csBase = '0; csMask = '0; csWait = '0; dramBase = '0; dramMask = '0; dramWait = '0;
    csBase[0*AW +: AW] = 28'h0100000; csMask[0*AW +: AW] = 28'h00FFFFF;
    csBase[1*AW +: AW] = 28'h0200000; csMask[1*AW +: AW] = 28'h00FFFFF;
    csBase[2*AW +: AW] = 28'h0200000; csMask[2*AW +: AW] = 28'h01FFFFF;
    csBase[3*AW +: AW] = 28'hA000000; csMask[3*AW +: AW] = 28'h0FFFFFF;
    csRdEn = 4'b0111; csWrEn = 4'b1101; csAutoAck = 4'b0111;
    csWait[0 +: 4] = 4'd2; csWait[4 +: 4] = 4'd0; csWait[8 +: 4] = 4'd5; csWait[12 +: 4] = 4'd1;
    dramBase[0 +: AW] = 28'h1000000; dramMask[0 +: AW] = 28'h00FFFFF;
    dramBase[AW +: AW] = 28'h4000000; dramMask[AW +: AW] = 28'h3FFFFFF;
    dramRdEn = 2'b11; dramWrEn = 2'b01;
    dramWait[0 +: 4] = 4'd1; dramWait[4 +: 4] = 4'd3;
    dfltAutoAck = 1'b1; dfltWait = 4'd4;

    addrs[0] = 28'h0123454; alts[0] = 1'b0;
    addrs[1] = 28'h0200002; alts[1] = 1'b0;
    addrs[2] = 28'h0300001; alts[2] = 1'b0;
    addrs[3] = 28'hA000003; alts[3] = 1'b0;
    addrs[4] = 28'h1000010; alts[4] = 1'b0;
    addrs[5] = 28'h4000000; alts[5] = 1'b0;
    addrs[6] = 28'h0800000; alts[6] = 1'b0;
    addrs[7] = 28'hA123456; alts[7] = 1'b1;

    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 reset outputs", {27'h0, ackOut, dramSel, csOut, weOut}, 32'h0);
    rstN = 1'b1;

    // sweep across windows, directions and size codes
    for (int k = 0; k < 8; k++)
      for (int r = 0; r < 2; r++)
        for (int s = 0; s < 4; s++)
          xfer(addrs[k], r[0], s[1:0], alts[k]);

    // R2: same address without the upper-bit clearing lands in window 3
    xfer(28'hA123456, 1'b0, 2'b00, 1'b0);

    // R8: default space with auto-acknowledge off
    dfltAutoAck = 1'b0;
    xfer(28'h0800000, 1'b1, 2'b00, 1'b0);
    dfltAutoAck = 1'b1;

    // R11: second start strobe inside an open default access
    @(negedge clk);
    addrIn = 28'h0800000; readNotWrite = 1'b1; upperPinsAlt = 1'b0; startStrobe = 1'b1;
    @(negedge clk);
    startStrobe = 1'b0;
    @(negedge clk);
    addrIn = 28'h0100000; startStrobe = 1'b1;
    @(negedge clk);
    startStrobe = 1'b0;
    begin
      int ackSeen = 0;
      int csSeen = 0;
      for (int n = 0; n < 16; n++) begin
        @(negedge clk);
        if (ackOut) ackSeen++;
        if (csOut != 0) csSeen++;
      end
      chk("R11 ignored start gives no chip select", csSeen, 0);
      chk("R11 one acknowledge only", ackSeen, 1);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule